// File: doc/BRIEF.md
# Split-Register Free-Running Timestamp Counter

This block is a free-running time base for a chip that needs a monotonic, wide timestamp. A 40-bit up-counter advances by one on each cycle in which the external fast tick input is high, and only while counting is switched on. It never signals an interrupt and it has no status flags. When the count passes all ones it wraps to zero.

Software sees the count through two 32-bit registers on a simple bus-slave port. The low register holds count bits 31:0. The high register holds the upper byte in bits 7:0 and the run control in bit 8. Each read of the low register copies the upper byte into a shadow register, and a high-register read returns that shadow. A low-then-high read pair therefore gives one consistent 40-bit value, even when the counter carries into the upper byte between the two accesses.

Read data is registered. It appears together with a one-cycle valid strobe in the cycle after the request.

Top module: `tstamp_timer`

## Requirements
- R1: After reset the count, the run control, the shadow byte and `rvalid_o` are all zero.
- R2: While the run control is set, the count rises by exactly one on every rising clock edge at which `tick_i` is high, and holds on edges at which it is low.
- R3: The run control is bit 8 of the high register (offset 0x64). Writing it as 0 sets the count to zero and keeps it there whatever `tick_i` does. Writing it as 1 from the stopped state starts counting from zero. Writing 1 while already running leaves the count untouched.
- R4: A read of the low register (offset 0x60) returns count bits LO_W-1:0, zero-extended, on `rdata_o` with `rvalid_o` high in the cycle after the request. Every read request is answered with `rvalid_o` for exactly that one cycle.
- R5: A read of the high register returns the shadow byte in bits HI_W-1:0, the current run control in bit 8, and zero in all other bits.
- R6: A low-register read copies the count's upper bits into the shadow. Later high-register reads return that copy until the next low read, even if the counter has carried into its upper bits in between.
- R7: From all ones the count wraps to zero on the next tick, with no flag or other side effect.
- R8: Writes to the low register or to unmapped offsets change neither the count nor the run control. Bits of a high-register write other than bit 8 are ignored. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-advance enable, one cycle per tick |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The counter is driven in several ways. A burst of consecutive ticks checks the basic step. Sparse, gapped ticks separate "advance per tick" from "advance per clock". Ticks sent while stopped confirm that the clear-and-hold really ignores the tick input. The bench uses a narrow instance so that the carry into the upper field and the wrap from all ones can both be reached. A tick placed between the low and high reads separates a shadowed upper byte from a live one. Writes carrying stray data bits, writes to the low register, and writes to unmapped offsets check that only bit 8 of the high register has an effect.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned RUN_BIT = 8;
  localparam logic [7:0]  LO_OFS = 8'h60;
  localparam logic [7:0]  HI_OFS = 8'h64;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/tstamp_decode.sv
module tstamp_decode
  import tstamp_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output rd_sel_e           rd_sel_o,
  output logic              rd_any_o,
  output logic              run_wr_o,
  output logic              run_val_o
);
  localparam logic [ADDR_W-1:0] LoA = ADDR_W'(LO_OFS);
  localparam logic [ADDR_W-1:0] HiA = ADDR_W'(HI_OFS);

  logic hit_lo, hit_hi;
  logic unused_wdata;

  assign hit_lo = (addr_i == LoA);
  assign hit_hi = (addr_i == HiA);

  assign rd_any_o  = req_i && !we_i;
  assign run_wr_o  = req_i && we_i && hit_hi;
  assign run_val_o = wdata_i[RUN_BIT];
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rd_sel_o = SEL_NONE;
    if (rd_any_o) begin
      if (hit_lo)      rd_sel_o = SEL_LO;
      else if (hit_hi) rd_sel_o = SEL_HI;
    end
  end
endmodule

// File: rtl/tstamp_count.sv
module tstamp_count #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_wr_i,
  input  logic             run_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 1'b0;
    else if (run_wr_i) run_q <= run_val_i;
  end

  // stopped counter is held at zero, so a restart begins from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_q) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tstamp_snap.sv
module tstamp_snap
  import tstamp_pkg::*;
#(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 8,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rd_sel_e          rd_sel_i,
  input  logic             rd_any_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  output logic [HI_W-1:0]  shadow_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             rvalid_o
);
  logic [HI_W-1:0]  shadow_q;
  logic [REG_W-1:0] rdata_d, rdata_q;
  logic             rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 shadow_q <= '0;
    else if (rd_sel_i == SEL_LO) shadow_q <= cnt_i[CNT_W-1:LO_W];
  end

  always_comb begin
    rdata_d = '0;
    unique case (rd_sel_i)
      SEL_LO: rdata_d[LO_W-1:0] = cnt_i[LO_W-1:0];
      SEL_HI: begin
        rdata_d[HI_W-1:0] = shadow_q;
        rdata_d[RUN_BIT]  = run_i;
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_any_i;
      if (rd_any_i) rdata_q <= rdata_d;
    end
  end

  assign shadow_o = shadow_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer
  import tstamp_pkg::*;
#(
  parameter int unsigned LO_W   = 32,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvalid_o
);
  rd_sel_e          rd_sel;
  logic             rd_any, run_wr, run_val, run;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  shadow;

  tstamp_decode #(.ADDR_W(ADDR_W)) i_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rd_sel_o  (rd_sel),
    .rd_any_o  (rd_any),
    .run_wr_o  (run_wr),
    .run_val_o (run_val)
  );

  tstamp_count #(.CNT_W(CNT_W)) i_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_wr_i  (run_wr),
    .run_val_i (run_val),
    .cnt_o     (cnt),
    .run_o     (run)
  );

  tstamp_snap #(.LO_W(LO_W), .HI_W(HI_W)) i_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (rd_sel),
    .rd_any_i (rd_any),
    .cnt_i    (cnt),
    .run_i    (run),
    .shadow_o (shadow),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: rtl/tstamp_chk.sv
module tstamp_chk
  import tstamp_pkg::*;
#(
  parameter int unsigned LO_W   = 32,
  parameter int unsigned HI_W   = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              rvalid_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              run,
  input logic [HI_W-1:0]   shadow
);
  logic rd_lo, rd_hi, rd;
  assign rd    = req_i && !we_i;
  assign rd_lo = rd && (addr_i == ADDR_W'(LO_OFS));
  assign rd_hi = rd && (addr_i == ADDR_W'(HI_OFS));

  // R2
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && tick_i |=> cnt == $past(cnt) + CNT_W'(1));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !tick_i |=> $stable(cnt));
  // R3
  a_r3_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt == '0);
  // R4
  a_r4_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  a_r4_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  a_r4_lo_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> rdata_o == REG_W'($past(cnt[LO_W-1:0])));
  // R5
  a_r5_hi_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |=> (rdata_o[REG_W-1:RUN_BIT+1] == '0) && (rdata_o[RUN_BIT] == $past(run)));
  // R6
  a_r6_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> shadow == $past(cnt[CNT_W-1:LO_W]));
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo |=> $stable(shadow));
  a_r6_hi_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |=> rdata_o[HI_W-1:0] == $past(shadow));
endmodule

bind tstamp_timer tstamp_chk #(.LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .cnt      (cnt),
  .run      (run),
  .shadow   (shadow)
);

// File: tb/test_tstamp_timer.sv
module test_tstamp_timer;
  localparam int unsigned LO_W = 6;
  localparam int unsigned HI_W = 3;
  localparam logic [7:0] A_LO = 8'h60;
  localparam logic [7:0] A_HI = 8'h64;
  localparam logic [7:0] A_XX = 8'h68;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tstamp_timer #(.LO_W(LO_W), .HI_W(HI_W), .ADDR_W(8)) i_tstamp_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    chk("R4 rvalid", 32'(rvalid_o), 32'd1);
    d = rdata_o;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rvalid after reset", 32'(rvalid_o), 32'd0);
    rd(A_LO, d); chk("R1 low zero", d, 32'h0);
    rd(A_HI, d); chk("R1 high zero", d, 32'h0);
    @(negedge clk);
    chk("R4 rvalid single cycle", 32'(rvalid_o), 32'd0);
  endtask

  task automatic t_stopped;
    logic [31:0] d;
    ticks(5);
    rd(A_LO, d); chk("R3 ticks ignored while stopped", d, 32'h0);
  endtask

  task automatic t_run_burst;
    logic [31:0] d;
    wr(A_HI, 32'h100);
    ticks(10);
    rd(A_LO, d); chk("R2 burst of 10", d, 32'd10);
    rd(A_HI, d); chk("R5 high layout running", d, 32'h100);
  endtask

  task automatic t_gapped;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      ticks(1);
      repeat (3) @(negedge clk);
    end
    rd(A_LO, d); chk("R2 gapped ticks", d, 32'd14);
  endtask

  task automatic t_ignored_writes;
    logic [31:0] d;
    wr(A_LO, 32'hFFFF_FFFF);
    wr(A_XX, 32'h0);
    wr(A_HI, 32'h0000_0100);
    rd(A_LO, d); chk("R8 count after ignored writes", d, 32'd14);
    rd(A_HI, d); chk("R8 run kept", d, 32'h100);
    rd(A_XX, d); chk("R8 unmapped read zero", d, 32'h0);
  endtask

  task automatic t_stop_restart;
    logic [31:0] d;
    wr(A_HI, 32'hFFFF_FEFF);
    rd(A_LO, d); chk("R3 stop clears count", d, 32'h0);
    rd(A_HI, d); chk("R3 stop clears run", d, 32'h0);
    ticks(4);
    rd(A_LO, d); chk("R3 held while stopped", d, 32'h0);
    wr(A_HI, 32'h0000_01FF);
    ticks(3);
    rd(A_LO, d); chk("R3 restart from zero", d, 32'd3);
    rd(A_HI, d); chk("R8 stray high bits ignored", d, 32'h100);
  endtask

  task automatic t_tear_free;
    logic [31:0] d;
    ticks(60);
    rd(A_LO, d); chk("R6 low at 63", d, 32'h3F);
    ticks(1);
    rd(A_HI, d); chk("R6 shadow not live", d, 32'h100);
    rd(A_HI, d); chk("R6 repeated high read", d, 32'h100);
    rd(A_LO, d); chk("R6 low after carry", d, 32'h0);
    rd(A_HI, d); chk("R6 shadow updated", d, 32'h101);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    ticks(447);
    rd(A_LO, d); chk("R7 low at max", d, 32'h3F);
    rd(A_HI, d); chk("R7 high at max", d, 32'h107);
    ticks(1);
    rd(A_LO, d); chk("R7 wrap low", d, 32'h0);
    rd(A_HI, d); chk("R7 wrap high", d, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_stopped();
    t_run_burst();
    t_gapped();
    t_ignored_writes();
    t_stop_restart();
    t_tear_free();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule